// File: doc/BRIEF.md
# Edge-Detect GPIO Interrupt Unit

This unit watches a vector of already-synchronized GPIO inputs and, for every pin, latches a rising edge, a falling edge or either one into a status word. Software arms each pin through two independent enable words: one for rising edges, one for falling edges. Software then finds pending pins by scanning the status words, lowest bit first. It acknowledges a pin by writing a one to that pin's status bit. A single interrupt line is high whenever any status bit anywhere is set.

The unit sits behind the simple word-addressed register port of the surrounding GPIO controller. Each register group occupies a run of `NW = ceil(NUM_PINS/32)` consecutive word addresses, and the group order follows the controller's shared layout. Pin `p` lives at bit `p % 32` of word `p / 32` in every group. Reads are registered and take one cycle. A pin count that is not a multiple of 32 leaves unused upper bits, and those bits are held at zero.

Top module: `gpio_edge_irq`

## Requirements
- R1: Rising-enable word `w` is at address `4*NW + w` and falling-enable word `w` is at address `5*NW + w`. A write replaces the word, and a read returns the stored value.
- R2: When a pin's sampled value goes from 0 to 1 and its rising enable is set, its bit in status word `w` (address `6*NW + w`) is set at the clock edge that samples the new value. The bit stays set until it is cleared.
- R3: When a pin goes from 1 to 0 and its falling enable is set, its status bit is set in the same way. With both enables set, either edge latches, and no edge of a disabled direction latches.
- R4: Writing a status word clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing all ones clears the whole word.
- R5: If an enabled edge on a pin is detected in the same cycle that a status write clears that pin's bit, the bit stays set.
- R6: Without an enabled edge or a clearing write, status bits hold their value. Changing an enable bit never clears a latched status bit.
- R7: `irq_o` is registered. After each clock edge it equals the OR of all status bits as they stand after that edge.
- R8: Reset clears every enable and status bit, `reg_rdata_o` and `irq_o`. Edge detection compares against a previous sample that reset sets to 0.
- R9: Addresses outside the three groups read as 0, and writes to them have no effect. Status and enable bits above `NUM_PINS` read as 0 and cannot be set.
- R10: `reg_rdata_o` loads the addressed word one edge after `reg_rd_i` and holds when there is no read. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Synchronized GPIO input levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Aggregated edge interrupt |

## Verification
The bench builds the unit with `NUM_PINS = 48` and `ADDR_W = 8`. This gives two words per group, the second of them only half populated, so writes of all ones can probe the masking of the unused bits at addresses 9, 11 and 13. The groups sit at addresses 8 to 13, and a scan of all sixteen addresses also reaches the unmapped space on both sides. Random sparse pin toggles run together with random enable writes and status clears, so edges often collide with clears on the same pin. Directed cases pin down each of those collisions explicitly.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int WORD_W   = 32;
  // Group order shared with the controller address map
  localparam int GRP_RISE = 4;
  localparam int GRP_FALL = 5;
  localparam int GRP_STAT = 6;

  function automatic int words_for(input int pins);
    return (pins + WORD_W - 1) / WORD_W;
  endfunction
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_i;
  end

  assign rise_o = pin_i & ~prev_q;
  assign fall_o = ~pin_i & prev_q;

  // R2
  rise_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_o != '0) |=> ((prev_q & $past(rise_o)) == $past(rise_o)));
  // R3
  fall_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_o != '0) |=> ((prev_q & $past(fall_o)) == '0));
endmodule

// File: rtl/gpio_edge_word.sv
module gpio_edge_word
  import gpio_edge_pkg::*;
#(
  parameter int VALID_BITS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rise_ev_i,
  input  logic [WORD_W-1:0] fall_ev_i,
  input  logic              wr_rise_i,
  input  logic              wr_fall_i,
  input  logic              wr_stat_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rise_en_o,
  output logic [WORD_W-1:0] fall_en_o,
  output logic [WORD_W-1:0] stat_o,
  output logic [WORD_W-1:0] stat_nxt_o
);
  localparam logic [63:0]       ONES64 = (64'd1 << VALID_BITS) - 64'd1;
  localparam logic [WORD_W-1:0] VMASK  = ONES64[WORD_W-1:0];

  logic [WORD_W-1:0] rise_en_q, fall_en_q, stat_q;
  logic [WORD_W-1:0] hit, clr;

  assign hit        = ((rise_ev_i & rise_en_q) | (fall_ev_i & fall_en_q)) & VMASK;
  assign clr        = wr_stat_i ? wdata_i : '0;
  assign stat_nxt_o = ((stat_q & ~clr) | hit) & VMASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      stat_q    <= '0;
    end else begin
      if (wr_rise_i) rise_en_q <= wdata_i & VMASK;
      if (wr_fall_i) fall_en_q <= wdata_i & VMASK;
      stat_q <= stat_nxt_o;
    end
  end

  assign rise_en_o = rise_en_q;
  assign fall_en_o = fall_en_q;
  assign stat_o    = stat_q;

  // R5
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((stat_q & $past(hit)) == $past(hit)));
  // R4
  clear_done_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~hit) != '0) |=> ((stat_q & $past(clr & ~hit)) == '0));
  // R6
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clr == '0 && hit == '0) |=> $stable(stat_q));
  // R9
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_q | rise_en_q | fall_en_q) & ~VMASK) == '0);
endmodule

// File: rtl/gpio_edge_regif.sv
module gpio_edge_regif
  import gpio_edge_pkg::*;
#(
  parameter int NW     = 2,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NW*WORD_W-1:0] rise_all_i,
  input  logic [NW*WORD_W-1:0] fall_all_i,
  input  logic [NW*WORD_W-1:0] stat_all_i,
  output logic [NW-1:0]        wr_rise_o,
  output logic [NW-1:0]        wr_fall_o,
  output logic [NW-1:0]        wr_stat_o,
  output logic [WORD_W-1:0]    rdata_o
);
  logic [WORD_W-1:0] rval;
  logic [WORD_W-1:0] rdata_q;

  always_comb begin
    rval      = '0;
    wr_rise_o = '0;
    wr_fall_o = '0;
    wr_stat_o = '0;
    for (int w = 0; w < NW; w++) begin
      if (addr_i == ADDR_W'(GRP_RISE * NW + w)) begin
        rval         = rise_all_i[w*WORD_W +: WORD_W];
        wr_rise_o[w] = wr_i;
      end
      if (addr_i == ADDR_W'(GRP_FALL * NW + w)) begin
        rval         = fall_all_i[w*WORD_W +: WORD_W];
        wr_fall_o[w] = wr_i;
      end
      if (addr_i == ADDR_W'(GRP_STAT * NW + w)) begin
        rval         = stat_all_i[w*WORD_W +: WORD_W];
        wr_stat_o[w] = wr_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rval;
  end

  assign rdata_o = rdata_q;

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_q));
  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({wr_rise_o, wr_fall_o, wr_stat_o}) <= 1);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                irq_o
);
  localparam int NW = words_for(NUM_PINS);
  localparam int TW = NW * WORD_W;

  logic [NUM_PINS-1:0] rise_raw, fall_raw;
  logic [TW-1:0]       rise_ev, fall_ev;
  logic [TW-1:0]       rise_all, fall_all, stat_all, stat_nxt_all;
  logic [NW-1:0]       wr_rise, wr_fall, wr_stat;
  logic                irq_q;

  gpio_edge_detect #(.WIDTH(NUM_PINS)) u_detect (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_i),
    .rise_o (rise_raw),
    .fall_o (fall_raw)
  );

  always_comb begin
    rise_ev                 = '0;
    fall_ev                 = '0;
    rise_ev[NUM_PINS-1:0]   = rise_raw;
    fall_ev[NUM_PINS-1:0]   = fall_raw;
  end

  gpio_edge_regif #(.NW(NW), .ADDR_W(ADDR_W)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .rise_all_i (rise_all),
    .fall_all_i (fall_all),
    .stat_all_i (stat_all),
    .wr_rise_o  (wr_rise),
    .wr_fall_o  (wr_fall),
    .wr_stat_o  (wr_stat),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int LEFT = NUM_PINS - w * WORD_W;
    localparam int VB   = (LEFT >= WORD_W) ? WORD_W : LEFT;
    gpio_edge_word #(.VALID_BITS(VB)) u_word (
      .clk        (clk),
      .rst        (rst),
      .rise_ev_i  (rise_ev[w*WORD_W +: WORD_W]),
      .fall_ev_i  (fall_ev[w*WORD_W +: WORD_W]),
      .wr_rise_i  (wr_rise[w]),
      .wr_fall_i  (wr_fall[w]),
      .wr_stat_i  (wr_stat[w]),
      .wdata_i    (reg_wdata_i),
      .rise_en_o  (rise_all[w*WORD_W +: WORD_W]),
      .fall_en_o  (fall_all[w*WORD_W +: WORD_W]),
      .stat_o     (stat_all[w*WORD_W +: WORD_W]),
      .stat_nxt_o (stat_nxt_all[w*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |stat_nxt_all;
  end

  assign irq_o = irq_q;

  // R7
  irq_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (stat_all != '0));
endmodule

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;
  localparam int NP = 48;
  localparam int NW = 2;
  localparam int AW = 8;
  localparam int TW = NW * 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NP-1:0] pin;
  logic          wr, rd;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic          irq;

  gpio_edge_irq #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .pin_i(pin), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  logic [TW-1:0] m_er, m_ef, m_st, m_prev, vmask;
  logic [31:0]   exp_rd;
  logic          exp_irq;
  string         rd_tag;
  int            n_chk, n_bad;
  bit            done;

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    int ai = int'(a);
    if (ai >= 8  && ai < 10) return m_er[(ai-8)*32 +: 32];
    if (ai >= 10 && ai < 12) return m_ef[(ai-10)*32 +: 32];
    if (ai >= 12 && ai < 14) return m_st[(ai-12)*32 +: 32];
    return 32'd0;
  endfunction

  function automatic string auto_tag(input logic [AW-1:0] a);
    int ai = int'(a);
    if (ai >= 8 && ai < 12)  return "R1 enable readback";
    if (ai >= 12 && ai < 14) return "R2 status readback";
    return "R9 unmapped read";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [NP-1:0] p, input logic w, input logic r,
                     input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    logic [TW-1:0] pp, hit, clr;
    int ai;
    @(negedge clk);
    check(rd_tag, rdata, exp_rd);
    check("R7 irq", {31'd0, irq}, {31'd0, exp_irq});
    pin = p; wr = w; rd = r; addr = a; wdata = d;
    ai = int'(a);
    pp = '0;
    pp[NP-1:0] = p;
    if (r) begin
      exp_rd = model_read(a);
      rd_tag = (tag != "") ? tag : auto_tag(a);
    end
    hit = ((pp & ~m_prev & m_er) | (~pp & m_prev & m_ef)) & vmask;
    clr = '0;
    if (w && ai >= 12 && ai < 14) clr[(ai-12)*32 +: 32] = d;
    m_st = ((m_st & ~clr) | hit) & vmask;
    if (w && ai >= 8 && ai < 10)  m_er[(ai-8)*32 +: 32]  = d & vmask[(ai-8)*32 +: 32];
    if (w && ai >= 10 && ai < 12) m_ef[(ai-10)*32 +: 32] = d & vmask[(ai-10)*32 +: 32];
    m_prev  = pp;
    exp_irq = |m_st;
  endtask

  initial begin
    void'($urandom(32'd2024));
    pin = '0; wr = 0; rd = 0; addr = '0; wdata = '0;
    m_er = '0; m_ef = '0; m_st = '0; m_prev = '0;
    vmask = '0; vmask[NP-1:0] = '1;
    exp_rd = '0; exp_irq = 0; rd_tag = "R8 reset rdata";
    n_chk = 0; n_bad = 0; done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    for (int a = 0; a < 16; a++) cyc('0, 0, 1, AW'(a), 0, "R8 reset value");
    cyc('0, 1, 0, 8, 32'h1, "");
    cyc('0, 1, 0, 10, 32'h2, "");
    cyc('0, 1, 0, 9, 32'h1, "");
    cyc('0, 1, 0, 11, 32'h1, "");
    cyc('0, 1, 0, 3, 32'hFFFF_FFFF, "");
    cyc('0, 0, 1, 3, 0, "R9 unmapped write ignored");
    cyc('0, 1, 0, 9, 32'hFFFF_FFFF, "");
    cyc('0, 0, 1, 9, 0, "R9 upper bits zero");
    cyc('0, 1, 0, 9, 32'h1, "");
    cyc('0, 0, 1, 8, 0, "R1 rise enable");
    cyc('0, 0, 1, 10, 0, "R1 fall enable");
    // pin0 rises with rise enabled
    cyc(48'h1, 0, 0, 0, 0, "");
    cyc(48'h1, 0, 1, 12, 0, "R2 rise latch");
    // pin1 rises, only falling enabled
    cyc(48'h3, 0, 0, 0, 0, "");
    cyc(48'h3, 0, 1, 12, 0, "R3 disabled rise");
    cyc(48'h1, 0, 0, 0, 0, "");
    cyc(48'h1, 0, 1, 12, 0, "R3 fall latch");
    // pin32 has both enables
    cyc(48'h1_0000_0001, 0, 0, 0, 0, "");
    cyc(48'h1_0000_0001, 0, 1, 13, 0, "R3 both rise");
    cyc(48'h1_0000_0001, 1, 0, 13, 32'h1, "");
    cyc(48'h1, 0, 0, 0, 0, "");
    cyc(48'h1, 0, 1, 13, 0, "R3 both fall");
    cyc(48'h1, 1, 0, 13, 32'hFFFF_FFFF, "");
    // W1C
    cyc(48'h1, 1, 0, 12, 32'h0, "");
    cyc(48'h1, 0, 1, 12, 0, "R4 write zero keeps");
    cyc(48'h1, 1, 0, 12, 32'h1, "");
    cyc(48'h1, 0, 1, 12, 0, "R4 write one clears");
    // edge coincides with clear
    cyc(48'h0, 0, 0, 0, 0, "");
    cyc(48'h1, 1, 0, 12, 32'h1, "");
    cyc(48'h1, 0, 1, 12, 0, "R5 edge beats clear");
    // disabling does not clear
    cyc(48'h1, 1, 0, 8, 32'h0, "");
    cyc(48'h1, 0, 1, 12, 0, "R6 enable drop keeps");
    cyc(48'h0, 0, 0, 0, 0, "");
    cyc(48'h1, 0, 1, 12, 0, "R6 disabled edge ignored");
    cyc(48'h1, 1, 1, 8, 32'h5, "R10 read before write");
    cyc(48'h1, 0, 0, 0, 0, "");
    cyc(48'h1, 0, 0, 0, 0, "R10 rdata hold");
    cyc(48'h1, 1, 0, 12, 32'hFFFF_FFFF, "");
    cyc(48'h1, 0, 1, 12, 0, "R4 clear word");

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] flip;
      logic [NP-1:0] np;
      logic w, r;
      logic [AW-1:0] a;
      logic [31:0] d;
      int op;
      flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      np = pin ^ flip[NP-1:0];
      op = int'($urandom % 8);
      w = 0; r = ($urandom % 2) == 0; a = AW'($urandom % 16); d = $urandom;
      if (op < 2) begin w = 1; a = AW'(8 + $urandom % 4); end
      else if (op == 2) begin
        w = 1; a = AW'(12 + $urandom % 2);
        if ($urandom % 4 == 0) d = 32'hFFFF_FFFF; else d = $urandom & $urandom;
      end
      else if (op == 3) begin w = 1; end
      else if (op < 6) begin r = 1; a = AW'(12 + $urandom % 2); end
      cyc(np, w, r, a, d, "");
    end
    cyc(pin, 0, 0, 0, 0, "");
    cyc(pin, 0, 0, 0, 0, "");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule